// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

A memory-mapped timer peripheral holding three reloadable down-counters and one free-running 40-bit timestamp counter, all reached through a simple single-cycle 32-bit register bus. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each down-counter is clocked by one of two tick strobes: a slow one and a fast one. It runs in periodic mode, reloading from its load register, or in free-running mode, wrapping to all ones. Every underflow raises a sticky interrupt flag.

The timestamp counter advances on a third tick strobe once its enable bit is set. It is read as a low word and a high word and never raises an interrupt. The tick strobes come from outside as one-cycle enables in the bus clock domain. The three interrupt lines go to an external interrupt controller.

Periodic use follows a fixed sequence. Write the control register with the enable bit clear, then write the load value, then write the control register again with the enable bit set.

Top module: `tmr_bank`

## Requirements
- R1: Register map, byte addresses, word aligned. Channel c has its load at base+0x0, live value at base+0x4, control at base+0x8 and interrupt clear at base+0xC. The bases are 0x00, 0x20 and 0x80 for channels 0, 1 and 2. The timestamp reads its low word at 0x60 and its high word at 0x64. Reads of unmapped addresses return 0. Accesses with bus_addr[1:0] not 00 are ignored.
- R2: The control fields are bit 7 = enable, bit 6 = periodic and bit 3 = fast tick select. A control read returns these three bits and zero elsewhere. A disabled channel holds its value.
- R3: An enabled channel counts down by one on each pulse of its selected tick (tick_fast when bit 3 is set, tick_slow otherwise). Pulses of the other tick have no effect on it.
- R4: In periodic mode, a load value N gives an underflow every N+1 selected ticks. At underflow the counter reloads N.
- R5: In free-running mode, an underflow wraps the counter to the all-ones value of its width: 0xFFFF for channels 0 and 1, 0xFFFFFFFF for channel 2.
- R6: A write to the load register also sets the live value, which is readable in the next cycle. A load write wins over a tick in the same cycle.
- R7: Channels 0 and 1 keep only bits 15:0 of a load write. Bits 31:16 of their load and value registers read as 0.
- R8: An underflow sets that channel's irq bit one cycle later. The bit stays set until a write of any data to the channel's clear register. If an underflow and a clear happen in the same cycle, the bit stays set.
- R9: The timestamp counts up by one per tick_stamp pulse while bit 8 of the 0x64 register is set. A read of 0x64 returns the enable at bit 8 and count bits 39:32 at bits 7:0. The timestamp drives no irq line.
- R10: After reset all counters, loads, controls and irq bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| tick_slow | input | 1 | Slow tick enable |
| tick_fast | input | 1 | Fast tick enable |
| tick_stamp | input | 1 | Timestamp tick enable |
| irq | output | 3 | Per-channel sticky underflow flags |

## Verification
A register write takes effect at the clock edge that samples it, and read data is combinational. The bench therefore reads a written value back in the next cycle. A tick pulse changes the live value at the edge that samples the pulse. The irq bit for that underflow appears at the same edge, so it is visible one cycle after the tick is presented. Inputs are driven at the falling edge and outputs are sampled one time unit later. Every check then looks at the state left by the last rising edge, never at a value in the middle of an update. The periodic sweep counts ticks until irq rises and compares that count with N+1 worked out by arithmetic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W       = 8;
  localparam int NUM_CH       = 3;
  localparam int EN_BIT       = 7;
  localparam int PER_BIT      = 6;
  localparam int FAST_BIT     = 3;
  localparam int STAMP_EN_BIT = 8;
  localparam logic [ADDR_W-1:0] STAMP_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] STAMP_HI_ADDR = 8'h64;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } chan_reg_e;

  function automatic logic [ADDR_W-1:0] chan_base(int c);
    case (c)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(logic en, logic per, logic fast);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]   = en;
    w[PER_BIT]  = per;
    w[FAST_BIT] = fast;
    return w;
  endfunction
endpackage

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic         wr_clr,
  input  logic [W-1:0] ld_data,
  input  logic         ctl_en,
  input  logic         ctl_per,
  input  logic         ctl_fast,
  input  logic         tick_slow,
  input  logic         tick_fast,
  output logic [W-1:0] value_o,
  output logic [W-1:0] load_o,
  output logic         en_o,
  output logic         per_o,
  output logic         fast_o,
  output logic         uflow_o,
  output logic         irq_o
);
  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic periodic,
                                              logic [W-1:0] reload);
    if (cur == '0) return periodic ? reload : '1;
    return cur - 1'b1;
  endfunction

  logic tick_sel;
  assign tick_sel = fast_o ? tick_fast : tick_slow;
  assign uflow_o  = en_o && tick_sel && (value_o == '0) && !wr_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_o <= '0;
      load_o  <= '0;
      en_o    <= 1'b0;
      per_o   <= 1'b0;
      fast_o  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_o   <= ctl_en;
        per_o  <= ctl_per;
        fast_o <= ctl_fast;
      end
      if (wr_load) begin
        load_o  <= ld_data;
        value_o <= ld_data;
      end else if (en_o && tick_sel) begin
        value_o <= next_count(value_o, per_o, load_o);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_o <= 1'b0;
    else if (uflow_o) irq_o <= 1'b1;
    else if (wr_clr)  irq_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         en_d,
  input  logic         tick,
  output logic [W-1:0] count_o,
  output logic         en_o
);
  function automatic logic [W-1:0] step(logic [W-1:0] cur);
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      en_o    <= 1'b0;
    end else begin
      if (wr_en) en_o <= en_d;
      if (en_o && tick) count_o <= step(count_o);
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int SW = 40
) (
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [NUM_CH-1:0][31:0] load_q,
  input  logic [NUM_CH-1:0][31:0] value_q,
  input  logic [NUM_CH-1:0][31:0] ctrl_q,
  input  logic [SW-1:0]          stamp_q,
  input  logic                   stamp_en,
  output logic [NUM_CH-1:0]      wr_load,
  output logic [NUM_CH-1:0]      wr_ctrl,
  output logic [NUM_CH-1:0]      wr_clr,
  output logic                   wr_stamp,
  output logic [31:0]            rdata
);
  logic        aligned;
  chan_reg_e   sel_reg;
  logic [NUM_CH-1:0] ch_hit;
  logic [31:0] hi_word;

  assign aligned = bus_sel && (bus_addr[1:0] == 2'b00);
  assign sel_reg = chan_reg_e'(bus_addr[3:2]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = chan_base(c);
    assign ch_hit[c]  = aligned && (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    assign wr_load[c] = ch_hit[c] && bus_wr && (sel_reg == REG_LOAD);
    assign wr_ctrl[c] = ch_hit[c] && bus_wr && (sel_reg == REG_CTRL);
    assign wr_clr[c]  = ch_hit[c] && bus_wr && (sel_reg == REG_CLEAR);
  end

  assign wr_stamp = aligned && bus_wr && (bus_addr == STAMP_HI_ADDR);
  assign hi_word  = 32'(stamp_q[SW-1:32]) | (32'(stamp_en) << STAMP_EN_BIT);

  always_comb begin
    rdata = '0;
    if (aligned && !bus_wr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_hit[c]) begin
          case (sel_reg)
            REG_LOAD:  rdata = load_q[c];
            REG_VALUE: rdata = value_q[c];
            REG_CTRL:  rdata = ctrl_q[c];
            default:   rdata = '0;
          endcase
        end
      end
      if (bus_addr == STAMP_LO_ADDR) rdata = stamp_q[31:0];
      if (bus_addr == STAMP_HI_ADDR) rdata = hi_word;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int STAMP_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tick_stamp,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0][31:0] load_q, value_q, ctrl_q;
  logic [NUM_CH-1:0]       wr_load, wr_ctrl, clr_wr, uflow;
  logic                    wr_stamp, stamp_en;
  logic [STAMP_W-1:0]      stamp_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int CW = (c == NUM_CH - 1) ? WIDE_W : NARROW_W;
    logic [CW-1:0] val_w, ld_w;
    logic          en_w, per_w, fast_w;

    tmr_down #(.W(CW)) u_down (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_load  (wr_load[c]),
      .wr_ctrl  (wr_ctrl[c]),
      .wr_clr   (clr_wr[c]),
      .ld_data  (bus_wdata[CW-1:0]),
      .ctl_en   (bus_wdata[EN_BIT]),
      .ctl_per  (bus_wdata[PER_BIT]),
      .ctl_fast (bus_wdata[FAST_BIT]),
      .tick_slow(tick_slow),
      .tick_fast(tick_fast),
      .value_o  (val_w),
      .load_o   (ld_w),
      .en_o     (en_w),
      .per_o    (per_w),
      .fast_o   (fast_w),
      .uflow_o  (uflow[c]),
      .irq_o    (irq[c])
    );

    assign value_q[c] = 32'(val_w);
    assign load_q[c]  = 32'(ld_w);
    assign ctrl_q[c]  = ctrl_word(en_w, per_w, fast_w);
  end

  tmr_stamp #(.W(STAMP_W)) u_stamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_stamp),
    .en_d   (bus_wdata[STAMP_EN_BIT]),
    .tick   (tick_stamp),
    .count_o(stamp_q),
    .en_o   (stamp_en)
  );

  tmr_regif #(.SW(STAMP_W)) u_regif (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .load_q  (load_q),
    .value_q (value_q),
    .ctrl_q  (ctrl_q),
    .stamp_q (stamp_q),
    .stamp_en(stamp_en),
    .wr_load (wr_load),
    .wr_ctrl (wr_ctrl),
    .wr_clr  (clr_wr),
    .wr_stamp(wr_stamp),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int SW = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] uflow,
  input logic [NUM_CH-1:0] clr_wr,
  input logic [SW-1:0]     stamp_q,
  input logic              stamp_en,
  input logic              tick_stamp,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    AST_UFLOW_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[c] |=> irq[c]); // R8
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr[c] && !uflow[c]) |=> !irq[c]); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] && !clr_wr[c]) |=> irq[c]); // R8
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[c] && !uflow[c]) |=> !irq[c]); // R8
  end

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp_en && tick_stamp) |=> (stamp_q == $past(stamp_q) + 1'b1)); // R9
  AST_STAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stamp_en && tick_stamp) |=> $stable(stamp_q)); // R9
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == 8'h04 || bus_addr == 8'h24 ||
                            bus_addr == 8'h00 || bus_addr == 8'h20))
    |-> (bus_rdata[31:16] == 16'h0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0)); // R1
endmodule

bind tmr_bank tmr_chk #(.SW(STAMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .uflow     (uflow),
  .clr_wr    (clr_wr),
  .stamp_q   (stamp_q),
  .stamp_en  (stamp_en),
  .tick_stamp(tick_stamp),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_stamp = 1'b0;
  logic [2:0]  irq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tmr_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .tick_stamp(tick_stamp),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic s, logic f, logic t);
    @(negedge clk);
    tick_slow = s; tick_fast = f; tick_stamp = t;
    @(negedge clk);
    tick_slow = 1'b0; tick_fast = 1'b0; tick_stamp = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(8'h04, v); check("R10", v, 32'h0);
    rd(8'h84, v); check("R10", v, 32'h0);
    rd(8'h60, v); check("R10", v, 32'h0);
    rd(8'h08, v); check("R10", v, 32'h0);
    #1 check("R10", 32'(irq), 32'h0);

    // R1 unmapped and misaligned accesses
    rd(8'h40, v); check("R1", v, 32'h0);
    wr(8'h01, 32'h5);
    rd(8'h00, v); check("R1", v, 32'h0);
    wr(8'h20, 32'h33);
    rd(8'h20, v); check("R1", v, 32'h33);
    rd(8'h00, v); check("R1", v, 32'h0);

    // R2 control readback keeps bits 7, 6, 3
    wr(8'h08, 32'hFF);
    rd(8'h08, v); check("R2", v, 32'hC8);
    wr(8'h08, 32'h0);
    // R6 load sets value at once
    wr(8'h00, 32'h7);
    rd(8'h04, v); check("R6", v, 32'h7);
    // R2 disabled channel holds
    pulse(1, 1, 0);
    rd(8'h04, v); check("R2", v, 32'h7);

    // R4 periodic sweep on channel 0, slow tick
    for (int n = 0; n < 6; n++) begin
      int first_irq;
      first_irq = -1;
      wr(8'h08, 32'h40);
      wr(8'h00, 32'(n));
      wr(8'h0C, 32'h0);
      wr(8'h08, 32'hC0);
      for (int k = 1; k <= 2 * (n + 1); k++) begin
        pulse(1, 0, 0);
        if (irq[0] && first_irq < 0) first_irq = k;
        rd(8'h04, v);
        check("R4", v, 32'(n - (k % (n + 1))));
      end
      check("R4", 32'(first_irq), 32'(n + 1));
    end

    // R3 tick source selection on channel 1 (fast)
    wr(8'h28, 32'h08);
    wr(8'h20, 32'd10);
    wr(8'h28, 32'h88);
    pulse(1, 0, 0);
    rd(8'h24, v); check("R3", v, 32'd10);
    pulse(0, 1, 0);
    rd(8'h24, v); check("R3", v, 32'd9);
    // R6 reload while counting
    wr(8'h20, 32'd20);
    rd(8'h24, v); check("R6", v, 32'd20);
    wr(8'h28, 32'h0);

    // R5 free-running wrap, channel 0 narrow
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h80);
    pulse(1, 0, 0);
    rd(8'h04, v); check("R5", v, 32'h0);
    #1 check("R8", 32'(irq[0]), 32'h0);
    pulse(1, 0, 0);
    rd(8'h04, v); check("R5", v, 32'h0000FFFF);
    #1 check("R8", 32'(irq[0]), 32'h1);
    wr(8'h08, 32'h0);
    // R5 wide channel wrap
    wr(8'h80, 32'h0);
    wr(8'h88, 32'h80);
    pulse(1, 0, 0);
    rd(8'h84, v); check("R5", v, 32'hFFFFFFFF);
    #1 check("R8", 32'(irq[2]), 32'h1);
    wr(8'h88, 32'h0);

    // R7 truncation on narrow channel
    wr(8'h00, 32'h0001_2345);
    rd(8'h00, v); check("R7", v, 32'h2345);
    rd(8'h04, v); check("R7", v, 32'h2345);

    // R8 sticky, then clear by any data
    repeat (5) @(negedge clk);
    #1 check("R8", 32'(irq[0]), 32'h1);
    wr(8'h0C, 32'hDEAD_BEEF);
    #1 check("R8", 32'(irq[0]), 32'h0);
    check("R8", 32'(irq[2]), 32'h1);
    // R8 same-cycle underflow and clear: set wins
    wr(8'h80, 32'h0);
    wr(8'h88, 32'hC0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h8C; bus_wdata = 32'h0;
    tick_slow = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_slow = 1'b0;
    #1 check("R8", 32'(irq[2]), 32'h1);
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h1);
    #1 check("R8", 32'(irq[2]), 32'h0);

    // R9 timestamp
    wr(8'h64, 32'h100);
    rd(8'h64, v); check("R9", v, 32'h100);
    for (int i = 0; i < 5; i++) pulse(0, 0, 1);
    rd(8'h60, v); check("R9", v, 32'd5);
    pulse(1, 1, 0);
    rd(8'h60, v); check("R9", v, 32'd5);
    #1 check("R9", 32'(irq), 32'h0);
    wr(8'h64, 32'h0);
    pulse(0, 0, 1);
    pulse(0, 0, 1);
    rd(8'h60, v); check("R9", v, 32'd5);
    rd(8'h64, v); check("R9", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule